// File: doc/BRIEF.md
# Fully Associative Translation Buffer Slot Manager

This block owns the storage of a fully associative translation buffer of 64 slots. Each slot pairs a 64-bit tag with a 64-bit translation word. Bit 63 of the translation word marks the slot valid and bit 6 marks it locked. Software-style commands reach the block through a single command port, and each command is answered one cycle later. The commands are: write or read one of sixteen control registers, insert a translation where the block chooses, write a translation into a slot named by the command address, and search the buffer for a tag.

Every translation written into a slot takes its tag from control register 6, the tag staging register. Automatic insertion picks the lowest-numbered invalid slot. When no slot is invalid, it picks the lowest-numbered unlocked slot. When every slot is valid and locked, the insertion is discarded and a one-cycle failure flag is raised. Control register 3 holds fault status, and any write to it clears it.

Top module: `tlb_slot_mgr`

## Requirements
- R1: After a synchronous reset, every slot is invalid with a zero tag, every control register reads zero, and resp_valid and insert_fail are low.
- R2: Op code 0 (register write) stores op_wdata into the control register selected by op_addr[6:3]. Op code 1 (register read) returns that register on resp_data.
- R3: A register write to index 3 (fault status) always leaves that register at zero, whatever the write data.
- R4: Op code 2 (insert) writes the tag from register 6 and the translation word op_wdata into the lowest-indexed slot whose bit 63 is clear, and reports that slot on resp_idx.
- R5: When all slots have bit 63 set, an insert goes to the lowest-indexed slot whose bit 6 is clear, and reports that slot on resp_idx.
- R6: When every slot has both bit 63 and bit 6 set, an insert changes no slot and raises insert_fail for exactly the response cycle.
- R7: Op code 3 (direct write) writes the tag from register 6 and op_wdata into the slot selected by op_addr[8:3], and reports that index on resp_idx.
- R8: Op code 4 (lookup) compares op_wdata with the tags of valid slots. It returns the tag of the lowest-indexed matching valid slot on resp_data and that slot's index on resp_idx, with resp_hit high. An invalid slot never matches.
- R9: A lookup that matches no valid slot returns resp_data of zero with resp_miss high and resp_hit low.
- R10: Each accepted command with op code 0 to 4 yields resp_valid high in the cycle after it is presented. That cycle carries the response fields for the command; fields that do not apply are zero. A command sees every slot and register change made by the command in the previous cycle. A cycle without a command gives resp_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Command present this cycle |
| op_code | input | 3 | 0 reg write, 1 reg read, 2 insert, 3 direct write, 4 lookup |
| op_addr | input | 12 | Command address; [6:3] register index, [8:3] slot index |
| op_wdata | input | 64 | Write data, translation word or lookup tag |
| resp_valid | output | 1 | Response for the previous cycle's command |
| resp_data | output | 64 | Register read value or matched tag |
| resp_hit | output | 1 | Lookup found a valid matching slot |
| resp_miss | output | 1 | Lookup found no valid matching slot |
| resp_idx | output | 6 | Slot chosen by insert, direct write, or lookup hit |
| insert_fail | output | 1 | Insert dropped because all slots are valid and locked |

## Verification
A slot array whose valid or lock bits are wrong shows up at the ports at the next insert, as an unexpected resp_idx or a spurious insert_fail. A stored tag or word that is wrong shows up at the next lookup that should hit it, as a wrong hit index, a wrong tag, or a false miss. Because each command's response lands in the very next cycle, every slot write is tracked by a reference model. Lookups aimed at recently written tags catch a wrong state within a few commands of its cause. A fault status register that fails to clear is seen on the first read after the write.

// File: rtl/tlb_mgr_pkg.sv
package tlb_mgr_pkg;

    localparam int TAG_W      = 64;
    localparam int TTE_W      = 64;
    localparam int VALID_POS  = 63;
    localparam int LOCK_POS   = 6;
    localparam int FSR_SEL    = 3;
    localparam int TAGACC_SEL = 6;
    localparam int FIELD_LSB  = 3;

    typedef enum logic [2:0] {
        OP_REG_WR     = 3'd0,
        OP_REG_RD     = 3'd1,
        OP_INSERT     = 3'd2,
        OP_DIRECT_WR  = 3'd3,
        OP_LOOKUP     = 3'd4
    } tlb_op_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [TTE_W-1:0] tte;
    } tlb_slot_t;

    function automatic logic slot_is_valid(input logic [TTE_W-1:0] w);
        return w[VALID_POS];
    endfunction

    function automatic logic slot_is_locked(input logic [TTE_W-1:0] w);
        return w[LOCK_POS];
    endfunction

endpackage

// File: rtl/tlb_prio_find.sv
module tlb_prio_find #(
    parameter int W  = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = i[IW-1:0];
        end
    end

    assign found = |req;

    // R4/R5/R8: the chosen index is a set request and no lower request is set
    always_comb begin
        if (found) begin
            a_pick_is_set_r4: assert (req[idx]);
            for (int j = 0; j < W; j++) begin
                if (j < int'(idx)) a_pick_is_lowest_r5: assert (!req[j]);
            end
        end
    end

endmodule

// File: rtl/tlb_ctrl_regs.sv
module tlb_ctrl_regs
    import tlb_mgr_pkg::*;
#(
    parameter int N_REGS = 16,
    localparam int RIW   = $clog2(N_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [RIW-1:0]   widx,
    input  logic [TTE_W-1:0] wdata,
    input  logic [RIW-1:0]   rd_idx,
    output logic [TTE_W-1:0] rd_data,
    output logic [TAG_W-1:0] tag_stage
);

    logic [TTE_W-1:0] regs [N_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_REGS; i++) regs[i] <= '0;
        end else if (we) begin
            if (int'(widx) == FSR_SEL) regs[widx] <= '0;
            else                       regs[widx] <= wdata;
        end
    end

    assign rd_data   = regs[rd_idx];
    assign tag_stage = regs[TAGACC_SEL];

    p_fsr_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (we && int'(widx) == FSR_SEL) |=> (regs[FSR_SEL] == '0));

    p_stage_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(tag_stage));

endmodule

// File: rtl/tlb_slot_array.sv
module tlb_slot_array
    import tlb_mgr_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    localparam int IW       = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [IW-1:0]        widx,
    input  tlb_slot_t            wslot,
    input  logic [TAG_W-1:0]     cmp_tag,
    input  logic [IW-1:0]        rd_idx,
    output logic [TAG_W-1:0]     rd_tag,
    output logic [N_ENTRIES-1:0] valid_vec,
    output logic [N_ENTRIES-1:0] unlock_vec,
    output logic [N_ENTRIES-1:0] match_vec
);

    tlb_slot_t mem [N_ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENTRIES; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wslot;
        end
    end

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        assign valid_vec[g]  = slot_is_valid(mem[g].tte);
        assign unlock_vec[g] = !slot_is_locked(mem[g].tte);
        assign match_vec[g]  = slot_is_valid(mem[g].tte) && (mem[g].tag == cmp_tag);
    end

    assign rd_tag = mem[rd_idx].tag;

    p_slot_lands_r7: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(widx)] == $past(wslot)));

endmodule

// File: rtl/tlb_slot_mgr.sv
module tlb_slot_mgr
    import tlb_mgr_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    parameter int N_REGS    = 16,
    parameter int ADDR_W    = 12,
    localparam int IW       = $clog2(N_ENTRIES),
    localparam int RIW      = $clog2(N_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [63:0]       op_wdata,
    output logic              resp_valid,
    output logic [63:0]       resp_data,
    output logic              resp_hit,
    output logic              resp_miss,
    output logic [IW-1:0]     resp_idx,
    output logic              insert_fail
);

    logic [IW-1:0]  ent_sel;
    logic [RIW-1:0] reg_sel;
    logic           unused_addr_bits;

    assign ent_sel = op_addr[FIELD_LSB +: IW];
    assign reg_sel = op_addr[FIELD_LSB +: RIW];
    assign unused_addr_bits = ^{op_addr[FIELD_LSB-1:0], op_addr[ADDR_W-1:FIELD_LSB+IW]};

    logic is_reg_wr, is_reg_rd, is_insert, is_direct, is_lookup;
    assign is_reg_wr = op_valid && (op_code == OP_REG_WR);
    assign is_reg_rd = op_valid && (op_code == OP_REG_RD);
    assign is_insert = op_valid && (op_code == OP_INSERT);
    assign is_direct = op_valid && (op_code == OP_DIRECT_WR);
    assign is_lookup = op_valid && (op_code == OP_LOOKUP);

    logic [TTE_W-1:0] reg_rd_data;
    logic [TAG_W-1:0] tag_stage;

    tlb_ctrl_regs #(.N_REGS(N_REGS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (is_reg_wr),
        .widx      (reg_sel),
        .wdata     (op_wdata),
        .rd_idx    (reg_sel),
        .rd_data   (reg_rd_data),
        .tag_stage (tag_stage)
    );

    logic [N_ENTRIES-1:0] valid_vec, unlock_vec, match_vec;
    logic                 inv_found, unl_found, hit_found;
    logic [IW-1:0]        inv_idx, unl_idx, hit_idx;
    logic [TAG_W-1:0]     hit_tag;

    tlb_prio_find #(.W(N_ENTRIES)) u_find_invalid (
        .req (~valid_vec), .found (inv_found), .idx (inv_idx)
    );
    tlb_prio_find #(.W(N_ENTRIES)) u_find_unlocked (
        .req (unlock_vec), .found (unl_found), .idx (unl_idx)
    );
    tlb_prio_find #(.W(N_ENTRIES)) u_find_hit (
        .req (match_vec), .found (hit_found), .idx (hit_idx)
    );

    logic          ins_ok;
    logic [IW-1:0] ins_idx;
    logic          slot_we;
    logic [IW-1:0] slot_widx;
    tlb_slot_t     slot_wdata;

    assign ins_ok     = inv_found || unl_found;
    assign ins_idx    = inv_found ? inv_idx : unl_idx;
    assign slot_we    = (is_insert && ins_ok) || is_direct;
    assign slot_widx  = is_direct ? ent_sel : ins_idx;
    assign slot_wdata = '{tag: tag_stage, tte: op_wdata};

    tlb_slot_array #(.N_ENTRIES(N_ENTRIES)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .we         (slot_we),
        .widx       (slot_widx),
        .wslot      (slot_wdata),
        .cmp_tag    (op_wdata),
        .rd_idx     (hit_idx),
        .rd_tag     (hit_tag),
        .valid_vec  (valid_vec),
        .unlock_vec (unlock_vec),
        .match_vec  (match_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid  <= 1'b0;
            resp_data   <= '0;
            resp_hit    <= 1'b0;
            resp_miss   <= 1'b0;
            resp_idx    <= '0;
            insert_fail <= 1'b0;
        end else begin
            resp_valid  <= is_reg_wr || is_reg_rd || is_insert || is_direct || is_lookup;
            resp_data   <= '0;
            resp_hit    <= 1'b0;
            resp_miss   <= 1'b0;
            resp_idx    <= '0;
            insert_fail <= 1'b0;
            if (is_reg_rd) resp_data <= reg_rd_data;
            if (is_insert) begin
                insert_fail <= !ins_ok;
                if (ins_ok) resp_idx <= ins_idx;
            end
            if (is_direct) resp_idx <= ent_sel;
            if (is_lookup) begin
                resp_hit  <= hit_found;
                resp_miss <= !hit_found;
                if (hit_found) begin
                    resp_data <= hit_tag;
                    resp_idx  <= hit_idx;
                end
            end
        end
    end

    p_fail_cause_r6: assert property (@(posedge clk) disable iff (rst)
        insert_fail |-> $past(op_valid && op_code == OP_INSERT));

    p_miss_zero_r9: assert property (@(posedge clk) disable iff (rst)
        resp_miss |-> (resp_data == '0 && !resp_hit));

    p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $countones({resp_hit, resp_miss, insert_fail}) <= 1);

    p_resp_follows_r10: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(op_valid));

endmodule

// File: tb/tlb_slot_mgr_bench.sv
module tlb_slot_mgr_bench;
    import tlb_mgr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [11:0] op_addr = '0;
    logic [63:0] op_wdata = '0;
    logic        resp_valid, resp_hit, resp_miss, insert_fail;
    logic [63:0] resp_data;
    logic [5:0]  resp_idx;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    tlb_slot_mgr u_tlb_slot_mgr (
        .clk (clk), .rst (rst), .op_valid (op_valid), .op_code (op_code),
        .op_addr (op_addr), .op_wdata (op_wdata), .resp_valid (resp_valid),
        .resp_data (resp_data), .resp_hit (resp_hit), .resp_miss (resp_miss),
        .resp_idx (resp_idx), .insert_fail (insert_fail)
    );

    logic [63:0] mtag [64];
    logic [63:0] mtte [64];
    logic [63:0] mreg [16];

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic int pick_insert();
        for (int k = 0; k < 64; k++) if (!mtte[k][63]) return k;
        for (int k = 0; k < 64; k++) if (!mtte[k][6]) return k;
        return -1;
    endfunction

    function automatic int pick_hit(input logic [63:0] t);
        for (int k = 0; k < 64; k++) if (mtte[k][63] && mtag[k] == t) return k;
        return -1;
    endfunction

    task automatic check(input string req, input logic [72:0] got, input logic [72:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got v=%0b d=%h h=%0b m=%0b i=%0d f=%0b exp v=%0b d=%h h=%0b m=%0b i=%0d f=%0b",
                req, got[72], got[71:8], got[7], got[6], got[5:0] >> 0, 1'b0,
                exp[72], exp[71:8], exp[7], exp[6], exp[5:0], 1'b0);
        end
    endtask

    // one command; responses compared against the reference model
    task automatic run_op(input logic [2:0] code, input int sel, input logic [63:0] wd, input string req);
        logic [63:0] e_data = '0;
        logic        e_hit = 0, e_miss = 0, e_fail = 0;
        int          e_idx = 0;
        int          k;
        case (code)
            OP_REG_WR: begin
                if (sel % 16 == 3) mreg[3] = '0; else mreg[sel % 16] = wd;
            end
            OP_REG_RD: e_data = mreg[sel % 16];
            OP_INSERT: begin
                k = pick_insert();
                if (k < 0) e_fail = 1;
                else begin mtag[k] = mreg[6]; mtte[k] = wd; e_idx = k; end
            end
            OP_DIRECT_WR: begin
                mtag[sel % 64] = mreg[6]; mtte[sel % 64] = wd; e_idx = sel % 64;
            end
            default: begin
                k = pick_hit(wd);
                if (k < 0) e_miss = 1;
                else begin e_hit = 1; e_data = mtag[k]; e_idx = k; end
            end
        endcase
        op_valid = 1'b1; op_code = code;
        op_addr  = 12'(sel % 64) << 3;
        op_wdata = wd;
        @(posedge clk); #2;
        checks++;
        if ({resp_valid, resp_data, resp_hit, resp_miss, resp_idx, insert_fail} !==
            {1'b1, e_data, e_hit, e_miss, 6'(e_idx), e_fail}) begin
            fails++;
            $display("FAIL %s op=%0d got v=%0b d=%h h=%0b m=%0b i=%0d f=%0b exp v=1 d=%h h=%0b m=%0b i=%0d f=%0b",
                req, code, resp_valid, resp_data, resp_hit, resp_miss, resp_idx, insert_fail,
                e_data, e_hit, e_miss, e_idx, e_fail);
        end
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic idle_check(input string req);
        @(posedge clk); #2;
        checks++;
        if (resp_valid !== 1'b0 || insert_fail !== 1'b0) begin
            fails++;
            $display("FAIL %s idle got v=%0b f=%0b exp v=0 f=0", req, resp_valid, insert_fail);
        end
        @(negedge clk);
    endtask

    localparam logic [63:0] V  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] LK = 64'h40;

    initial begin
        logic [63:0] w;
        int r;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin mtag[i] = '0; mtte[i] = '0; end
        for (int i = 0; i < 16; i++) mreg[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        idle_check("R1");
        run_op(OP_LOOKUP, 0, 64'h0, "R1 all slots invalid");
        run_op(OP_REG_RD, 6, 64'h0, "R1 register zero");

        // R2 / R3 registers
        run_op(OP_REG_WR, 9, 64'hDEAD_BEEF_0123_4567, "R2 write");
        run_op(OP_REG_RD, 9, 64'h0, "R2 read back");
        run_op(OP_REG_WR, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R3 write fsr");
        run_op(OP_REG_RD, 3, 64'h0, "R3 fsr cleared");

        // R4: fill all slots valid+locked except 10 and 40
        for (int i = 0; i < 64; i++) begin
            run_op(OP_REG_WR, 6, 64'h1000 + 64'(i), "R2 stage tag");
            run_op(OP_INSERT, 0, (i == 10 || i == 40) ? (V | 64'(i)) : (V | LK | 64'(i)), "R4 lowest invalid");
        end
        idle_check("R10");
        run_op(OP_REG_WR, 6, 64'hAAAA, "R2 stage tag");
        run_op(OP_INSERT, 0, V | LK | 64'h77, "R5 lowest unlocked");
        run_op(OP_INSERT, 0, V | LK | 64'h78, "R5 next unlocked");
        run_op(OP_INSERT, 0, V | 64'h79, "R6 all locked fail");
        run_op(OP_LOOKUP, 0, 64'h1000 + 64'd7, "R8 hit after fill");
        run_op(OP_DIRECT_WR, 5, 64'h0, "R7 invalidate slot 5");
        run_op(OP_INSERT, 0, V | LK | 64'h5, "R4 reuse invalid slot");
        run_op(OP_INSERT, 0, V, "R6 fail again");

        // R8: duplicate tags, lowest valid wins; invalid slot never matches
        run_op(OP_REG_WR, 6, 64'h5555, "R2 stage tag");
        run_op(OP_DIRECT_WR, 30, V | LK, "R7 direct 30");
        run_op(OP_DIRECT_WR, 20, V | LK, "R7 direct 20");
        run_op(OP_LOOKUP, 0, 64'h5555, "R8 lowest match");
        run_op(OP_DIRECT_WR, 20, LK, "R7 invalidate 20");
        run_op(OP_LOOKUP, 0, 64'h5555, "R8 skip invalid");
        run_op(OP_LOOKUP, 0, 64'h9999_0000, "R9 miss");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            r = int'($urandom % 100);
            w = {$urandom, $urandom};
            w[63] = ($urandom % 10) < 6;
            w[6]  = ($urandom % 4) == 0;
            if (r < 15) begin
                if ($urandom % 2 == 1) run_op(OP_REG_WR, 6, 64'($urandom % 8), "R2 random stage");
                else run_op(OP_REG_WR, int'($urandom % 16), {$urandom, $urandom}, "R2 R3 random write");
            end else if (r < 25) run_op(OP_REG_RD, int'($urandom % 16), 64'h0, "R2 random read");
            else if (r < 45) run_op(OP_INSERT, 0, w, "R4 R5 R6 random insert");
            else if (r < 65) run_op(OP_DIRECT_WR, int'($urandom % 64), w, "R7 random direct");
            else if (($urandom % 10) < 7) run_op(OP_LOOKUP, 0, mtag[$urandom % 64], "R8 random lookup");
            else run_op(OP_LOOKUP, 0, 64'($urandom % 12), "R9 random lookup");
            if (n % 500 == 0) idle_check("R10");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule